// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block owns the 4 KB configuration space of a function and runs two commands over the chain of extended capability headers kept in it. The chain starts at byte offset 0x100. Each header is one dword. It holds a 16-bit identifier in bits 15:0, a 4-bit version in bits 19:16 and the byte offset of the next header in bits 31:20, where 0 ends the chain. A search command walks the chain one header at a time. It returns the offset of the first header whose identifier matches, together with the offset of the header visited just before it.

An append command places a new header at a caller-chosen offset. When that offset is 0x100, the header is written there directly. At any other offset, the engine first walks the chain with a key that no header can match, which leaves it at the tail. It then rewrites only the next-offset field of the tail so that it points at the new header. The new header is written with a next field of 0. Both commands check every offset they visit against the legal window, and a step limit stops a corrupted chain that loops back on itself.

A host port reads and writes the configuration dwords directly while the engine is idle. The RAM has one cycle of read latency, and the engine allows for that latency on every header it visits.

Top module: `xcap_list_engine`

## Requirements
- R1: In the cycle after reset is released, busy, done, err, found_off and prev_off are all 0.
- R2: A walk reads its first header at byte offset 0x100. If that dword is all zeros, a search ends with found_off = 0, prev_off = 0 and err = 0. Header fields are id in bits 15:0, version in bits 19:16 and next offset in bits 31:20.
- R3: A search that meets a header whose id equals cmd_id returns that header's offset in found_off. It returns the offset of the previously visited header in prev_off, which is 0 when the match is at 0x100.
- R4: A search that reaches a header with next = 0 without a match returns found_off = 0, with prev_off set to the offset of that last header.
- R5: If a walk is about to visit an offset below 0x100, above 0xFF8 or not a multiple of 4, it stops with err = 1, found_off = 0 and prev_off = 0.
- R6: A walk that has visited MAX_STEPS (default 1024) headers without ending stops with err = 1.
- R7: An append at offset 0x100 writes {next = 0, cmd_ver, cmd_id} there without walking, and returns found_off = 0x100 and prev_off = 0.
- R8: An append at any other offset finds the tail. It rewrites bits 31:20 of the tail with the new offset and leaves bits 19:0 unchanged. It then writes {next = 0, cmd_ver, cmd_id} at the new offset and returns found_off = new offset and prev_off = tail offset.
- R9: An append whose cmd_size is below 8, whose cmd_off + cmd_size exceeds 0x1000, whose cmd_off is below 0x100, or whose cmd_off is not a multiple of 4 ends with err = 1 and writes nothing.
- R10: An append at an offset other than 0x100 on an empty chain ends with err = 1 and writes nothing.
- R11: busy is high from the cycle after a command is accepted until done. done is a one-cycle pulse in which busy is already low. A cmd_valid seen while busy is ignored.
- R12: While idle, host_we writes host_wdata to dword host_addr, and host_rdata shows the dword at host_addr one cycle later. Host writes while busy are ignored. A host write in the same cycle as a command accept is seen by that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host dword write strobe, honoured only while idle |
| host_addr | input | 10 | Host dword index (byte offset / 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | RAM read data, one cycle after the address |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_append | input | 1 | 1 = append, 0 = search |
| cmd_id | input | 16 | Capability identifier to find or to write |
| cmd_ver | input | 4 | Version for an appended header |
| cmd_off | input | 12 | Byte offset for an appended header |
| cmd_size | input | 13 | Byte size of an appended capability |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found_off | output | 12 | Match offset or appended offset, 0 for none |
| prev_off | output | 12 | Predecessor or tail offset |
| err | output | 1 | Last command ended in error |

## Verification
A host write and a command accept can land in the same cycle, because both are legal while the engine is idle. The bench drives a host write that places a fresh header at 0x100 on the same clock edge as a search for that header's identifier. The result is correct only if the walk, which reads 0x100 two cycles later, returns 0x100 with no error. The opposite case is also covered: host writes issued during a long looping walk must leave the RAM unchanged when it is read back afterwards.

// File: rtl/xcap_pkg.sv
package xcap_pkg;

    localparam int CFG_BYTES     = 4096;
    localparam int OFF_W         = $clog2(CFG_BYTES);
    localparam int DW_AW         = OFF_W - 2;
    localparam int DEPTH         = CFG_BYTES / 4;
    localparam int ID_W          = 16;
    localparam int VER_W         = 4;
    localparam int SIZE_W        = OFF_W + 1;
    localparam int SUM_W         = OFF_W + 2;
    localparam int MIN_CAP_BYTES = 8;
    localparam int KEY_W         = ID_W + 1;

    typedef logic [OFF_W-1:0] off_t;

    localparam off_t EXT_BASE = off_t'(256);
    localparam off_t LAST_HDR = off_t'(CFG_BYTES - 8);

    typedef struct packed {
        off_t             next;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } xhdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RD,
        ST_EVAL,
        ST_PATCH,
        ST_NEW
    } eng_state_e;

    function automatic logic hdr_off_ok(off_t o);
        return (o >= EXT_BASE) && (o <= LAST_HDR) && (o[1:0] == 2'b00);
    endfunction

    function automatic logic [DW_AW-1:0] dw_index(off_t o);
        return o[OFF_W-1:2];
    endfunction

    function automatic xhdr_t relink(xhdr_t h, off_t n);
        xhdr_t r;
        r      = h;
        r.next = n;
        return r;
    endfunction

endpackage

// File: rtl/xcap_cfg_ram.sv
module xcap_cfg_ram #(
    parameter int WORDS = 1024,
    parameter int AW    = $clog2(WORDS),
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/xcap_append_check.sv
module xcap_append_check
    import xcap_pkg::*;
(
    input  off_t              off,
    input  logic [SIZE_W-1:0] size,
    output logic              bad,
    output logic              at_base
);

    logic [SUM_W-1:0] span_end;
    logic             too_small;
    logic             past_end;
    logic             below_base;
    logic             unaligned;

    always_comb begin
        span_end   = {2'b00, off} + {1'b0, size};
        too_small  = size < SIZE_W'(MIN_CAP_BYTES);
        past_end   = span_end > SUM_W'(CFG_BYTES);
        below_base = off < EXT_BASE;
        unaligned  = off[1:0] != 2'b00;
        bad        = too_small | past_end | below_base | unaligned;
        at_base    = off == EXT_BASE;
    end

endmodule

// File: rtl/xcap_walk_engine.sv
module xcap_walk_engine
    import xcap_pkg::*;
#(
    parameter int MAX_STEPS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_append,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [VER_W-1:0]  cmd_ver,
    input  off_t              cmd_off,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              arg_bad,
    input  logic              arg_at_base,
    input  logic [31:0]       ram_rdata,
    output off_t              q_off,
    output logic [SIZE_W-1:0] q_size,
    output logic [DW_AW-1:0]  eng_raddr,
    output logic              eng_we,
    output logic [DW_AW-1:0]  eng_waddr,
    output logic [31:0]       eng_wdata,
    output logic              busy,
    output logic              done,
    output off_t              found_off,
    output off_t              prev_off,
    output logic              err
);

    localparam int STEP_W = $clog2(MAX_STEPS + 1);
    localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(MAX_STEPS);

    eng_state_e         state;
    off_t               cur;
    off_t               prv;
    xhdr_t              hdr_q;
    xhdr_t              rd_hdr;
    logic [STEP_W-1:0]  steps;
    logic [KEY_W-1:0]   key_q;
    logic [ID_W-1:0]    id_q;
    logic [VER_W-1:0]   ver_q;
    logic               app_q;
    logic               key_hit;

    assign rd_hdr  = xhdr_t'(ram_rdata);
    assign key_hit = key_q == {1'b0, rd_hdr.id};
    assign busy    = state != ST_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            prv       <= '0;
            hdr_q     <= '0;
            steps     <= '0;
            key_q     <= '0;
            id_q      <= '0;
            ver_q     <= '0;
            q_off     <= '0;
            q_size    <= '0;
            app_q     <= 1'b0;
            done      <= 1'b0;
            found_off <= '0;
            prev_off  <= '0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        app_q  <= cmd_append;
                        id_q   <= cmd_id;
                        ver_q  <= cmd_ver;
                        q_off  <= cmd_off;
                        q_size <= cmd_size;
                        key_q  <= cmd_append ? {1'b1, {ID_W{1'b0}}} : {1'b0, cmd_id};
                        state  <= ST_START;
                    end
                end
                ST_START: begin
                    cur   <= EXT_BASE;
                    prv   <= '0;
                    steps <= '0;
                    if (app_q && arg_bad) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        err       <= 1'b1;
                        found_off <= '0;
                        prev_off  <= '0;
                    end else if (app_q && arg_at_base) begin
                        cur   <= '0;
                        state <= ST_NEW;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (!hdr_off_ok(cur) || steps == STEP_LIM) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        err       <= 1'b1;
                        found_off <= '0;
                        prev_off  <= '0;
                    end else begin
                        state <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (steps == '0 && ram_rdata == '0) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        err       <= app_q;
                        found_off <= '0;
                        prev_off  <= '0;
                    end else if (key_hit) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        err       <= 1'b0;
                        found_off <= cur;
                        prev_off  <= prv;
                    end else if (rd_hdr.next == '0) begin
                        if (app_q) begin
                            hdr_q <= rd_hdr;
                            state <= ST_PATCH;
                        end else begin
                            state     <= ST_IDLE;
                            done      <= 1'b1;
                            err       <= 1'b0;
                            found_off <= '0;
                            prev_off  <= cur;
                        end
                    end else begin
                        prv   <= cur;
                        cur   <= rd_hdr.next;
                        steps <= steps + 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_PATCH: begin
                    state <= ST_NEW;
                end
                ST_NEW: begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    err       <= 1'b0;
                    found_off <= q_off;
                    prev_off  <= cur;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        eng_raddr = dw_index(cur);
        eng_we    = (state == ST_PATCH) || (state == ST_NEW);
        if (state == ST_PATCH) begin
            eng_waddr = dw_index(cur);
            eng_wdata = relink(hdr_q, q_off);
        end else begin
            eng_waddr = dw_index(q_off);
            eng_wdata = xhdr_t'{next: '0, ver: ver_q, id: id_q};
        end
    end

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_cmd_ignored_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(key_q) && $stable(q_off) && $stable(app_q)));

    assert_step_bound_R6: assert property (@(posedge clk) disable iff (rst)
        steps <= STEP_LIM);

endmodule

// File: rtl/xcap_list_engine.sv
module xcap_list_engine
    import xcap_pkg::*;
#(
    parameter int MAX_STEPS = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_we,
    input  logic [DW_AW-1:0]     host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    input  logic                 cmd_valid,
    input  logic                 cmd_append,
    input  logic [ID_W-1:0]      cmd_id,
    input  logic [VER_W-1:0]     cmd_ver,
    input  logic [OFF_W-1:0]     cmd_off,
    input  logic [SIZE_W-1:0]    cmd_size,
    output logic                 busy,
    output logic                 done,
    output logic [OFF_W-1:0]     found_off,
    output logic [OFF_W-1:0]     prev_off,
    output logic                 err
);

    off_t              q_off;
    logic [SIZE_W-1:0] q_size;
    logic              arg_bad;
    logic              arg_at_base;
    logic [DW_AW-1:0]  eng_raddr;
    logic              eng_we;
    logic [DW_AW-1:0]  eng_waddr;
    logic [31:0]       eng_wdata;
    logic              ram_we;
    logic [DW_AW-1:0]  ram_waddr;
    logic [31:0]       ram_wdata;
    logic [DW_AW-1:0]  ram_raddr;
    logic [31:0]       ram_rdata;

    xcap_append_check u_check (
        .off     (q_off),
        .size    (q_size),
        .bad     (arg_bad),
        .at_base (arg_at_base)
    );

    xcap_walk_engine #(
        .MAX_STEPS (MAX_STEPS)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_append  (cmd_append),
        .cmd_id      (cmd_id),
        .cmd_ver     (cmd_ver),
        .cmd_off     (cmd_off),
        .cmd_size    (cmd_size),
        .arg_bad     (arg_bad),
        .arg_at_base (arg_at_base),
        .ram_rdata   (ram_rdata),
        .q_off       (q_off),
        .q_size      (q_size),
        .eng_raddr   (eng_raddr),
        .eng_we      (eng_we),
        .eng_waddr   (eng_waddr),
        .eng_wdata   (eng_wdata),
        .busy        (busy),
        .done        (done),
        .found_off   (found_off),
        .prev_off    (prev_off),
        .err         (err)
    );

    always_comb begin
        if (busy) begin
            ram_we    = eng_we;
            ram_waddr = eng_waddr;
            ram_wdata = eng_wdata;
            ram_raddr = eng_raddr;
        end else begin
            ram_we    = host_we;
            ram_waddr = host_addr;
            ram_wdata = host_wdata;
            ram_raddr = host_addr;
        end
    end

    xcap_cfg_ram #(
        .WORDS (DEPTH),
        .AW    (DW_AW),
        .DW    (32)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign host_rdata = ram_rdata;

    assert_found_legal_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !err && found_off != '0) |-> (found_off >= EXT_BASE && found_off[1:0] == 2'b00));

    assert_err_clears_result_R5: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (found_off == '0 && prev_off == '0));

    assert_engine_writes_only_busy_R12: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> busy);

endmodule

// File: tb/test_xcap_list_engine.sv
`timescale 1ns/1ps
module test_xcap_list_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_append = 1'b0;
    logic [15:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0;
    logic [12:0] cmd_size = '0;
    logic        busy;
    logic        done;
    logic [11:0] found_off;
    logic [11:0] prev_off;
    logic        err;

    int vecs = 0;
    int miss = 0;
    logic [11:0] r_found;
    logic [11:0] r_prev;
    logic        r_err;
    logic [31:0] rd;

    always #4 clk = ~clk;

    xcap_list_engine i_xcap_list_engine (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cmd_valid  (cmd_valid),
        .cmd_append (cmd_append),
        .cmd_id     (cmd_id),
        .cmd_ver    (cmd_ver),
        .cmd_off    (cmd_off),
        .cmd_size   (cmd_size),
        .busy       (busy),
        .done       (done),
        .found_off  (found_off),
        .prev_off   (prev_off),
        .err        (err)
    );

    // id, expected found_off, expected prev_off (R3, R4)
    localparam logic [39:0] SEARCH_VEC [5] = '{
        {16'h0001, 12'h100, 12'h000},
        {16'h000E, 12'h140, 12'h100},
        {16'h0003, 12'h200, 12'h140},
        {16'h0055, 12'h000, 12'h200},
        {16'hFFFF, 12'h000, 12'h200}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = off[11:2];
        host_wdata = d;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_rd(input logic [11:0] off, output logic [31:0] d);
        @(negedge clk);
        host_addr = off[11:2];
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            check({tag, " timeout"}, 32'd0, 32'd1);
        end
        r_found = found_off;
        r_prev  = prev_off;
        r_err   = err;
    endtask

    task automatic launch(input logic app, input logic [15:0] id, input logic [3:0] ver,
                          input logic [11:0] off, input logic [12:0] size);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_append = app;
        cmd_id     = id;
        cmd_ver    = ver;
        cmd_off    = off;
        cmd_size   = size;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic run_cmd(input string tag, input logic app, input logic [15:0] id,
                           input logic [3:0] ver, input logic [11:0] off, input logic [12:0] size);
        launch(app, id, ver, off, size);
        wait_done(tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 err", {31'd0, err}, 32'd0);
        check("R1 found", {20'd0, found_off}, 32'd0);
        check("R1 prev", {20'd0, prev_off}, 32'd0);

        // Build chain 0x100 -> 0x140 -> 0x200 with host writes (R12)
        host_wr(12'h100, {12'h140, 4'h1, 16'h0001});
        host_wr(12'h140, {12'h200, 4'h1, 16'h000E});
        host_wr(12'h200, {12'h000, 4'h2, 16'h0003});
        host_rd(12'h140, rd);
        check("R12 host readback", rd, {12'h200, 4'h1, 16'h000E});

        // Table of searches (R3 match with predecessor, R4 miss with tail)
        for (int i = 0; i < 5; i++) begin
            run_cmd("R3 table", 1'b0, SEARCH_VEC[i][39:24], 4'h0, 12'h0, 13'h0);
            check("R3 R4 table found", {20'd0, r_found}, {20'd0, SEARCH_VEC[i][23:12]});
            check("R3 R4 table prev", {20'd0, r_prev}, {20'd0, SEARCH_VEC[i][11:0]});
            check("R3 R4 table err", {31'd0, r_err}, 32'd0);
        end

        // R5 out-of-window and misaligned next offsets
        host_wr(12'h200, {12'h080, 4'h2, 16'h0003});
        run_cmd("R5 low", 1'b0, 16'h0999, 4'h0, 12'h0, 13'h0);
        check("R5 below base err", {31'd0, r_err}, 32'd1);
        check("R5 below base found", {20'd0, r_found}, 32'd0);
        host_wr(12'h200, {12'hFFC, 4'h2, 16'h0003});
        run_cmd("R5 high", 1'b0, 16'h0999, 4'h0, 12'h0, 13'h0);
        check("R5 above window err", {31'd0, r_err}, 32'd1);
        host_wr(12'h200, {12'h142, 4'h2, 16'h0003});
        run_cmd("R5 align", 1'b0, 16'h0999, 4'h0, 12'h0, 13'h0);
        check("R5 misaligned err", {31'd0, r_err}, 32'd1);

        // R2 empty chain
        host_wr(12'h100, 32'h0);
        run_cmd("R2 empty", 1'b0, 16'h0001, 4'h0, 12'h0, 13'h0);
        check("R2 empty found", {20'd0, r_found}, 32'd0);
        check("R2 empty prev", {20'd0, r_prev}, 32'd0);
        check("R2 empty err", {31'd0, r_err}, 32'd0);

        // R10 append off-base on empty chain
        host_wr(12'h200, 32'hA5A5_0000);
        run_cmd("R10 append", 1'b1, 16'h0011, 4'h1, 12'h200, 13'd8);
        check("R10 err", {31'd0, r_err}, 32'd1);
        host_rd(12'h200, rd);
        check("R10 no write", rd, 32'hA5A5_0000);

        // R7 append at base
        run_cmd("R7 append", 1'b1, 16'h0010, 4'h2, 12'h100, 13'd8);
        check("R7 found", {20'd0, r_found}, 32'h100);
        check("R7 prev", {20'd0, r_prev}, 32'd0);
        check("R7 err", {31'd0, r_err}, 32'd0);
        host_rd(12'h100, rd);
        check("R7 header", rd, 32'h0002_0010);

        // R8 append after tail
        run_cmd("R8 append", 1'b1, 16'h0020, 4'h1, 12'h180, 13'd16);
        check("R8 found", {20'd0, r_found}, 32'h180);
        check("R8 prev", {20'd0, r_prev}, 32'h100);
        host_rd(12'h100, rd);
        check("R8 tail relinked", rd, 32'h1802_0010);
        host_rd(12'h180, rd);
        check("R8 new header", rd, 32'h0001_0020);
        run_cmd("R8 search", 1'b0, 16'h0020, 4'h0, 12'h0, 13'h0);
        check("R8 search found", {20'd0, r_found}, 32'h180);
        check("R8 search prev", {20'd0, r_prev}, 32'h100);
        run_cmd("R8 append2", 1'b1, 16'h0030, 4'h3, 12'h1C0, 13'd8);
        check("R8 second prev", {20'd0, r_prev}, 32'h180);
        host_rd(12'h180, rd);
        check("R8 second relink", rd, 32'h1C01_0020);

        // R9 argument checks
        host_wr(12'h300, 32'h5A5A_5A5A);
        run_cmd("R9 size", 1'b1, 16'h0040, 4'h1, 12'h300, 13'd4);
        check("R9 small size err", {31'd0, r_err}, 32'd1);
        run_cmd("R9 end", 1'b1, 16'h0040, 4'h1, 12'hFF8, 13'd16);
        check("R9 past end err", {31'd0, r_err}, 32'd1);
        run_cmd("R9 low", 1'b1, 16'h0040, 4'h1, 12'h0C0, 13'd8);
        check("R9 below base err", {31'd0, r_err}, 32'd1);
        run_cmd("R9 align", 1'b1, 16'h0040, 4'h1, 12'h302, 13'd8);
        check("R9 misaligned err", {31'd0, r_err}, 32'd1);
        host_rd(12'h300, rd);
        check("R9 no write target", rd, 32'h5A5A_5A5A);
        host_rd(12'h1C0, rd);
        check("R9 tail untouched", rd, 32'h0003_0030);
        run_cmd("R9 edge", 1'b1, 16'h0050, 4'h1, 12'hFF8, 13'd8);
        check("R9 exact end ok", {31'd0, r_err}, 32'd0);
        check("R9 exact end prev", {20'd0, r_prev}, 32'h1C0);

        // R11 busy, single done pulse, command ignored while busy
        host_wr(12'h400, 32'h0);
        launch(1'b0, 16'h0030, 4'h0, 12'h0, 13'h0);
        check("R11 busy after accept", {31'd0, busy}, 32'd1);
        cmd_valid  = 1'b1;
        cmd_append = 1'b1;
        cmd_id     = 16'h0044;
        cmd_off    = 12'h400;
        cmd_size   = 13'd8;
        @(negedge clk);
        cmd_valid  = 1'b0;
        wait_done("R11 walk");
        check("R11 busy low at done", {31'd0, busy}, 32'd0);
        check("R11 result kept", {20'd0, r_found}, 32'h1C0);
        check("R11 prev kept", {20'd0, r_prev}, 32'h180);
        @(negedge clk);
        check("R11 done one cycle", {31'd0, done}, 32'd0);
        host_rd(12'h400, rd);
        check("R11 ignored append", rd, 32'h0);
        host_rd(12'hFF8, rd);
        check("R11 tail unchanged", rd, 32'h0001_0050);

        // R6 looping chain, R12 host write while busy
        host_wr(12'h100, {12'h100, 4'h1, 16'h0001});
        host_wr(12'h300, 32'h0);
        launch(1'b0, 16'h0002, 4'h0, 12'h0, 13'h0);
        repeat (5) @(negedge clk);
        host_wr(12'h300, 32'hDEAD_BEEF);
        wait_done("R6 loop");
        check("R6 step limit err", {31'd0, r_err}, 32'd1);
        host_rd(12'h300, rd);
        check("R12 busy write ignored", rd, 32'h0);

        // R12 host write in the accept cycle
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = 10'h040;
        host_wdata = {12'h000, 4'h1, 16'h0077};
        cmd_valid  = 1'b1;
        cmd_append = 1'b0;
        cmd_id     = 16'h0077;
        @(negedge clk);
        host_we    = 1'b0;
        cmd_valid  = 1'b0;
        wait_done("R12 same cycle");
        check("R12 same cycle found", {20'd0, r_found}, 32'h100);
        check("R12 same cycle err", {31'd0, r_err}, 32'd0);

        finish_run();
    end

endmodule